// File: doc/BRIEF.md
# Serial Step-Attenuator Control Register

This block is the digital control front end of a 6-bit step attenuator. A host writes to it over three wires: a serial clock, a serial data line and a latch enable. The block collects the data bits in a shift register. When latch enable rises, it transfers them to a registered parallel word that drives the attenuator cells. A serial output repeats the bit pushed out of the top of the shift register, so several devices can share one data line in a chain.

All three pins are sampled in a faster system clock domain. Each pin passes through a two-flop synchronizer, and its edges are found there. A small state machine decides whether the shift register accepts serial clock edges. It has two states. In `ST_OPEN`, latch enable is low and shifting is allowed. In `ST_HOLD`, latch enable is high and the serial clock is gated off. The `T_LATCH` transition goes from `ST_OPEN` to `ST_HOLD` on a latch-enable rising edge and loads the parallel word. The `T_RELEASE` transition goes from `ST_HOLD` back to `ST_OPEN` on a latch-enable falling edge.

The control bits are active-low, and the word resets to all zeros, which selects full attenuation. A readout gives the latched attenuation in half-dB steps.

Top module: `atten_serial_ctrl`

## Requirements
- R1: During and after reset, `atten_word_o` is 000000, `atten_halfdb_o` is 63 and `ser_out_o` is 0.
- R2: With latch enable low, each rising edge of the serial clock shifts the serial data bit into bit 0 of the shift register, and the older bits move one place up. The first of six bits sent therefore ends up in bit 5 (D5), so the word is sent MSB first.
- R3: While latch enable is high, serial clock edges are ignored and the shift register keeps its contents.
- R4: A rising edge of latch enable copies the shift register to `atten_word_o`. At all other times `atten_word_o` holds its value, including while bits are being shifted.
- R5: Each control bit is active-low: a cleared bit i adds 2^i half-dB. All ones (63) is the reference insertion-loss state. `atten_halfdb_o` equals 63 minus `atten_word_o`.
- R6: A latch that follows fewer than six shifted bits still transfers whatever the register holds at that moment.
- R7: On each accepted serial clock edge, `ser_out_o` takes the value that bit 5 held just before the shift. It does not change at any other time.
- R8: If a serial clock rise and a latch-enable rise reach the system domain in the same cycle, the clock edge is discarded. The latched word is the register contents before that edge.
- R9: `atten_word_o` changes on the third system clock rising edge after the latch pin rises. This requires the system clock to run at least 4 times faster than the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin (asynchronous) |
| ser_dat_i | input | 1 | Serial data pin (asynchronous) |
| latch_i | input | 1 | Latch enable pin (asynchronous) |
| atten_word_o | output | 6 | Active-low attenuator control word |
| ser_out_o | output | 1 | Chained serial output |
| atten_halfdb_o | output | 6 | Latched attenuation in half-dB units |

## Verification
Two functions can fall in the same system cycle: accepting a serial clock edge and transferring the word on a latch-enable rise. The bench provokes this by raising both pins at the same instant, so they pass through identical synchronizers and reach the state machine together. The scoreboard's model then expects the pre-edge register contents to be latched, with the serial output unchanged. A later latch with no further shifting confirms that the discarded bit never entered the register.

// File: rtl/atten_pkg.sv
package atten_pkg;
    parameter int unsigned CTRL_W = 6;

    localparam int unsigned PIN_SCLK = 0;
    localparam int unsigned PIN_SDAT = 1;
    localparam int unsigned PIN_LE   = 2;
    localparam int unsigned PIN_N    = 3;

    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } gate_state_e;
endpackage

// File: rtl/atten_pin_sync.sv
module atten_pin_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[LAST];
    end

    assign lvl_o  = chain_q[LAST];
    assign rise_o = chain_q[LAST] & ~prev_q;
    assign fall_o = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/atten_shift_fsm.sv
module atten_shift_fsm
    import atten_pkg::*;
#(
    parameter int unsigned W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         sdat,
    input  logic         le_lvl,
    input  logic         le_rise,
    input  logic         le_fall,
    output logic [W-1:0] ctrl_o,
    output logic         ser_o
);
    localparam int unsigned TOP = W - 1;

    gate_state_e state_q, state_d;
    logic [W-1:0] shreg_q;
    logic [W-1:0] ctrl_q;
    logic         ser_q;
    logic         shift_en;
    logic         load_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (le_rise) state_d = ST_HOLD;
            ST_HOLD: if (le_fall) state_d = ST_OPEN;
            default: state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        load_en  = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                load_en  = le_rise;
                shift_en = sclk_rise && !le_lvl;
            end
            ST_HOLD: begin
                shift_en = sclk_rise && !le_lvl;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            ser_q   <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            if (shift_en) begin
                shreg_q <= {shreg_q[TOP-1:0], sdat};
                ser_q   <= shreg_q[TOP];
            end
            if (load_en) ctrl_q <= shreg_q;
        end
    end

    assign ctrl_o = ctrl_q;
    assign ser_o  = ser_q;

    a_r3_hold_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
        le_lvl |=> $stable(shreg_q));

    a_r4_latch_copies: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> (ctrl_q == $past(shreg_q)));

    a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(ctrl_q));

    a_r7_serout_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(ser_q));

    a_r8_no_shift_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && le_rise) |=> $stable(shreg_q));
endmodule

// File: rtl/atten_serial_ctrl.sv
module atten_serial_ctrl
    import atten_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              latch_i,
    output logic [CTRL_W-1:0] atten_word_o,
    output logic              ser_out_o,
    output logic [CTRL_W-1:0] atten_halfdb_o
);
    localparam logic [CTRL_W-1:0] REF_CODE = '1;

    logic [PIN_N-1:0] pins;
    logic [PIN_N-1:0] lvl;
    logic [PIN_N-1:0] rise;
    logic [PIN_N-1:0] fall;

    always_comb begin
        pins           = '0;
        pins[PIN_SCLK] = ser_clk_i;
        pins[PIN_SDAT] = ser_dat_i;
        pins[PIN_LE]   = latch_i;
    end

    atten_pin_sync #(.WIDTH(PIN_N), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    atten_shift_fsm #(.W(CTRL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (rise[PIN_SCLK]),
        .sdat      (lvl[PIN_SDAT]),
        .le_lvl    (lvl[PIN_LE]),
        .le_rise   (rise[PIN_LE]),
        .le_fall   (fall[PIN_LE]),
        .ctrl_o    (atten_word_o),
        .ser_o     (ser_out_o)
    );

    assign atten_halfdb_o = REF_CODE - atten_word_o;

    a_r5_ref_state_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_word_o == REF_CODE) |-> (atten_halfdb_o == '0));

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (atten_word_o == '0 && !ser_out_o));
endmodule

// File: tb/atten_serial_ctrl_test.sv
module atten_serial_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;

    typedef struct {
        logic [5:0] word;
        logic [5:0] halfdb;
        logic       so;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       latch = 1'b0;
    logic [5:0] word;
    logic       so;
    logic [5:0] halfdb;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    logic [5:0] sr_m = '0;
    logic [5:0] ctrl_m = '0;
    logic       so_m = 1'b0;
    logic       le_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atten_serial_ctrl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ser_clk_i      (ser_clk),
        .ser_dat_i      (ser_dat),
        .latch_i        (latch),
        .atten_word_o   (word),
        .ser_out_o      (so),
        .atten_halfdb_o (halfdb)
    );

    task automatic sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        e.word   = ctrl_m;
        e.halfdb = 6'd63 - ctrl_m;
        e.so     = so_m;
        e.tag    = tag;
        q.push_back(e);
        sys(2);
    endtask

    task automatic direct(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (word !== e.word || halfdb !== e.halfdb || so !== e.so) begin
                errors++;
                $display("FAIL %s actual word=%b halfdb=%0d so=%b expected word=%b halfdb=%0d so=%b",
                         e.tag, word, halfdb, so, e.word, e.halfdb, e.so);
            end
        end
    end

    task automatic sbit(input logic b);
        ser_dat = b;
        ser_clk = 1'b0;
        sys(HALF_SCLK);
        ser_clk = 1'b1;
        if (!le_m) begin
            so_m = sr_m[5];
            sr_m = {sr_m[4:0], b};
        end
        sys(HALF_SCLK);
        ser_clk = 1'b0;
    endtask

    task automatic send(input logic [5:0] w, input int nbits);
        for (int i = 5; i > 5 - nbits; i--) sbit(w[i]);
        sys(HALF_SCLK);
    endtask

    task automatic latch_up(input string tag);
        latch = 1'b1;
        le_m  = 1'b1;
        ctrl_m = sr_m;
        sys(5);
        expect_now(tag);
    endtask

    task automatic latch_down();
        latch = 1'b0;
        le_m  = 1'b0;
        sys(5);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sr_m = '0; ctrl_m = '0; so_m = 1'b0;
        sys(3);
        rst_n = 1'b1;
        sys(2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] old;
        sys(1);
        // R1: reset state
        direct("R1 word in reset", word, 6'b000000);
        do_reset();
        expect_now("R1 reset state");

        // R2 R5: all ones reference state
        send(6'b111111, 6);
        expect_now("R4 word held while shifting");
        latch_up("R5 reference state");
        latch_down();

        // R2: MSB first
        send(6'b100000, 6);
        latch_up("R2 msb first");
        latch_down();

        // R5: mixed pattern
        send(6'b101010, 6);
        latch_up("R5 mixed pattern");
        latch_down();

        // R7: serial out follows old D5
        sbit(1'b1);
        sys(HALF_SCLK);
        expect_now("R7 serout after first shift");
        sbit(1'b0);
        sys(HALF_SCLK);
        expect_now("R7 serout after second shift");

        // R6: short transfer
        send(6'b111111, 6);
        latch_up("R6 full reload");
        latch_down();
        send(6'b000000, 2);
        latch_up("R6 short transfer");

        // R3: clocks ignored while latch high
        send(6'b000000, 6);
        expect_now("R3 serout held while gated");
        latch_down();
        latch_up("R3 register unchanged by gated clocks");
        latch_down();

        // R9: latency of the transfer
        send(6'b010110, 6);
        old = ctrl_m;
        latch = 1'b1;
        le_m  = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        direct("R9 word before third edge", word, old);
        @(posedge clk); @(negedge clk);
        direct("R9 word at third edge", word, sr_m);
        ctrl_m = sr_m;
        sys(3);
        expect_now("R9 settled word");
        latch_down();

        // R8: serial clock rise coincident with latch rise
        send(6'b110011, 5);
        ser_dat = 1'b0;
        sys(HALF_SCLK);
        ser_clk = 1'b1;
        latch   = 1'b1;
        le_m    = 1'b1;
        ctrl_m  = sr_m;
        sys(5);
        expect_now("R8 coincident edge discarded");
        ser_clk = 1'b0;
        sys(HALF_SCLK);
        latch_down();
        latch_up("R8 register lacks discarded bit");
        latch_down();

        // R5: single cleared bits
        for (int k = 0; k < 6; k++) begin
            send(~(6'b1 << k), 6);
            latch_up("R5 single cleared bit");
            direct("R5 halfdb weight", halfdb, 6'(1 << k));
            latch_down();
        end

        // R1: reset mid-operation
        do_reset();
        expect_now("R1 reset after activity");

        sys(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule